// File: doc/BRIEF.md
# Dual-Mode 8-Bit Timer/Counter

An 8-bit timer/counter channel with two operating modes, of the kind used next to a small processor core. In reload mode the low count byte advances on each qualified count event. When it passes its maximum it takes the value held in the high byte, which serves as a fixed period register, and it raises overflow flag 0. In split mode the two bytes become independent counters. The low byte keeps the full source selection and gating and wraps to zero. The high byte counts prescaled clock ticks under run bit 1 and raises overflow flag 1.

The count source is either a free-running prescaler or falling edges on an external event pin. The prescaler divides the clock by 12 or by 6, as the divide-select input sets. Counting of the low byte can be gated by an external level. Software loads either count byte and clears the flags through a small write port. Per-flag acknowledge pulses from an interrupt controller clear the flags in hardware.

Top module: `dual_tmr8`

## Requirements
- R1: After reset both count bytes and both overflow flags read 0.
- R2: With split_mode=0, each low-byte count event increments cnt_lo. An event at cnt_lo=FFh instead loads cnt_lo with cnt_hi and sets ovf0. Counting never changes cnt_hi.
- R3: With ext_sel=0, a count event occurs once every d clocks while counting is enabled. d=12 when div_fast=0 and d=6 when div_fast=1. The prescaler runs freely from reset.
- R4: With ext_sel=1, one count event occurs for each 1-to-0 change of ev_pin between two consecutive clock samples.
- R5: The low byte counts only while run0=1 and either gate_en=0 or gate_pin=1. Otherwise cnt_lo holds.
- R6: With split_mode=1, the low byte keeps the sources and gating of R3 to R5 but wraps from FFh to 00h and sets ovf0. The high byte increments once per prescaler tick while run1=1, and it wraps from FFh to 00h and sets ovf1.
- R7: With split_mode=0, run1 has no effect: cnt_hi and ovf1 do not change except through the write port.
- R8: A pulse on vec_ack0 or vec_ack1 clears ovf0 or ovf1. A write with wr_sel=2 clears ovf0 where wr_data bit 0 is 1 and ovf1 where bit 1 is 1. A flag set in the same cycle wins over a clear.
- R9: A write with wr_sel=0 loads cnt_lo and a write with wr_sel=1 loads cnt_hi, visible from the next cycle. A write takes priority over a same-cycle count of that byte, and that count is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_fast | input | 1 | Prescaler divisor select: 0 = 12, 1 = 6 |
| split_mode | input | 1 | 0 = reload mode, 1 = split mode |
| ev_pin | input | 1 | External event input, falling edge counted |
| gate_pin | input | 1 | External gate level |
| run0 | input | 1 | Run bit for the low byte |
| run1 | input | 1 | Run bit for the high byte in split mode |
| gate_en | input | 1 | Gate enable for the low byte |
| ext_sel | input | 1 | Low byte source: 0 = prescaler, 1 = ev_pin |
| vec_ack0 | input | 1 | Clears ovf0 |
| vec_ack1 | input | 1 | Clears ovf1 |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target: 0 low, 1 high, 2 flag clear |
| wr_data | input | 8 | Write data |
| cnt_lo | output | 8 | Low count byte |
| cnt_hi | output | 8 | High count byte |
| ovf0 | output | 1 | Overflow flag 0 |
| ovf1 | output | 1 | Overflow flag 1 |

## Verification
The bench targets the FFh boundary in both modes. A design that confuses the modes either wraps to zero where it should reload from the high byte, or reloads in split mode. The bench measures the spacing between count events for both divisors, so an off-by-one prescaler shows up as a period of 11, 13, 5 or 7. It also checks that a held-low gate or a low-level event pin produces no counts: a level-sensitive event detector would count on every cycle. Finally it collides a write with a counting edge, and it lets run1 toggle in reload mode. A wrong priority would leave the incremented value in cnt_lo, and leaked control logic would move the high byte.

// File: rtl/dual_tmr8.sv
module dual_tmr8 #(
  parameter int W        = 8,
  parameter int DIV_FAST = 6,
  parameter int DIV_SLOW = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         div_fast,
  input  logic         split_mode,
  input  logic         ev_pin,
  input  logic         gate_pin,
  input  logic         run0,
  input  logic         run1,
  input  logic         gate_en,
  input  logic         ext_sel,
  input  logic         vec_ack0,
  input  logic         vec_ack1,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] cnt_lo,
  output logic [W-1:0] cnt_hi,
  output logic         ovf0,
  output logic         ovf1
);
  localparam int PW = $clog2(DIV_SLOW);

  logic [PW-1:0] pre;
  logic          ev_q;

  wire [PW-1:0] d_m1   = div_fast ? PW'(DIV_FAST - 1) : PW'(DIV_SLOW - 1);
  wire          tick   = pre >= d_m1;
  wire          fall   = ev_q & ~ev_pin;
  wire          en_lo  = run0 & (~gate_en | gate_pin);
  wire          inc_lo = en_lo & (ext_sel ? fall : tick);
  wire          inc_hi = split_mode & run1 & tick;
  wire          wr_lo  = wr_en & (wr_sel == 2'd0);
  wire          wr_hi  = wr_en & (wr_sel == 2'd1);
  wire          wr_flg = wr_en & (wr_sel == 2'd2);
  wire          lo_max = &cnt_lo;
  wire          hi_max = &cnt_hi;
  wire          set0   = inc_lo & lo_max & ~wr_lo;
  wire          set1   = inc_hi & hi_max & ~wr_hi;
  wire          clr0   = vec_ack0 | (wr_flg & wr_data[0]);
  wire          clr1   = vec_ack1 | (wr_flg & wr_data[1]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre    <= '0;
      ev_q   <= 1'b0;
      cnt_lo <= '0;
      cnt_hi <= '0;
      ovf0   <= 1'b0;
      ovf1   <= 1'b0;
    end else begin
      pre  <= tick ? '0 : pre + 1'b1;
      ev_q <= ev_pin;
      if (wr_lo)
        cnt_lo <= wr_data;
      else if (inc_lo)
        cnt_lo <= (lo_max && !split_mode) ? cnt_hi : cnt_lo + 1'b1;
      if (wr_hi)
        cnt_hi <= wr_data;
      else if (inc_hi)
        cnt_hi <= cnt_hi + 1'b1;
      ovf0 <= set0 | (ovf0 & ~clr0);
      ovf1 <= set1 | (ovf1 & ~clr1);
    end
  end

  AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!split_mode && inc_lo && lo_max && !wr_lo) |=> (cnt_lo == $past(cnt_hi)) && ovf0); // R2
  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R3
  AST_GATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_lo && !wr_lo) |=> $stable(cnt_lo)); // R5
  AST_SPLIT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (split_mode && inc_lo && lo_max && !wr_lo) |=> (cnt_lo == '0) && ovf0); // R6
  AST_HI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!split_mode && !wr_hi) |=> $stable(cnt_hi)); // R7
  AST_OVF1_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !split_mode |=> !$rose(ovf1)); // R7
  AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_ack0 && !set0) |=> !ovf0); // R8
  AST_WRITE_LO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> cnt_lo == $past(wr_data)); // R9
endmodule

// File: tb/dual_tmr8_bench.sv
module dual_tmr8_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic div_fast = 0, split_mode = 0, ev_pin = 0, gate_pin = 0;
  logic run0 = 0, run1 = 0, gate_en = 0, ext_sel = 0;
  logic vec_ack0 = 0, vec_ack1 = 0, wr_en = 0;
  logic [1:0] wr_sel = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] cnt_lo, cnt_hi;
  logic ovf0, ovf1;

  int checks = 0, errors = 0, cycles = 0;
  string phase = "R1";
  bit done = 0;

  always #10 clk = ~clk;

  dual_tmr8 u_dual_tmr8 (
    .clk(clk), .rst_n(rst_n), .div_fast(div_fast), .split_mode(split_mode),
    .ev_pin(ev_pin), .gate_pin(gate_pin), .run0(run0), .run1(run1),
    .gate_en(gate_en), .ext_sel(ext_sel), .vec_ack0(vec_ack0), .vec_ack1(vec_ack1),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .ovf0(ovf0), .ovf1(ovf1));

  int m_lo, m_hi, m_f0, m_f1, m_pre, m_evq;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lo = 0; m_hi = 0; m_f0 = 0; m_f1 = 0; m_pre = 0; m_evq = 0;
    end else begin
      int d, tk, fl, il, ih, s0, s1, nlo, nhi;
      d   = div_fast ? 6 : 12;
      tk  = (m_pre >= d - 1);
      fl  = (m_evq == 1 && ev_pin == 0);
      il  = run0 && (!gate_en || gate_pin) && (ext_sel ? fl : tk);
      ih  = split_mode && run1 && tk;
      nlo = m_lo; nhi = m_hi; s0 = 0; s1 = 0;
      if (il) begin
        if (m_lo == 255) begin s0 = 1; nlo = split_mode ? 0 : m_hi; end
        else nlo = m_lo + 1;
      end
      if (ih) begin
        if (m_hi == 255) begin s1 = 1; nhi = 0; end
        else nhi = m_hi + 1;
      end
      if (wr_en && wr_sel == 0) begin nlo = wr_data; s0 = 0; end
      if (wr_en && wr_sel == 1) begin nhi = wr_data; s1 = 0; end
      if (s0) m_f0 = 1;
      else if (vec_ack0 || (wr_en && wr_sel == 2 && wr_data[0])) m_f0 = 0;
      if (s1) m_f1 = 1;
      else if (vec_ack1 || (wr_en && wr_sel == 2 && wr_data[1])) m_f1 = 0;
      m_lo = nlo; m_hi = nhi;
      m_pre = tk ? 0 : m_pre + 1;
      m_evq = ev_pin;
    end
  end

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) begin
      check(phase, cnt_lo, m_lo, "model cnt_lo");
      check(phase, cnt_hi, m_hi, "model cnt_hi");
      check(phase, ovf0, m_f0, "model ovf0");
      check(phase, ovf1, m_f1, "model ovf1");
    end
    if (cycles > 150000 && !done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] s, logic [7:0] v);
    wr_en = 1; wr_sel = s; wr_data = v;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic pulse_ev(int n);
    for (int i = 0; i < n; i++) begin
      ev_pin = 0; @(negedge clk);
      ev_pin = 1; @(negedge clk);
    end
  endtask

  task automatic period(output int n);
    logic [7:0] v;
    v = cnt_lo;
    while (cnt_lo == v) @(negedge clk);
    v = cnt_lo; n = 0;
    while (cnt_lo == v) begin @(negedge clk); n++; end
  endtask

  initial begin
    int p;
    cyc(3);
    rst_n = 1;
    @(negedge clk);
    check("R1", cnt_lo, 0, "reset cnt_lo");
    check("R1", cnt_hi, 0, "reset cnt_hi");
    check("R1", ovf0, 0, "reset ovf0");
    check("R1", ovf1, 0, "reset ovf1");

    phase = "R3";
    wr(2'd1, 8'h00); wr(2'd0, 8'h00);
    run0 = 1;
    period(p); check("R3", p, 12, "period d=12");
    div_fast = 1;
    period(p); period(p); check("R3", p, 6, "period d=6");
    run0 = 0; div_fast = 0;

    phase = "R2";
    ext_sel = 1; ev_pin = 1; run0 = 1;
    wr(2'd1, 8'h80); wr(2'd0, 8'hFE);
    pulse_ev(2);
    check("R2", cnt_lo, 8'h80, "reload from high byte");
    check("R2", cnt_hi, 8'h80, "high byte unchanged");
    check("R2", ovf0, 1, "ovf0 set on reload");

    phase = "R8";
    vec_ack0 = 1; @(negedge clk); vec_ack0 = 0;
    check("R8", ovf0, 0, "ack clears ovf0");

    phase = "R4";
    wr(2'd0, 8'h10);
    pulse_ev(5);
    check("R4", cnt_lo, 8'h15, "five falling edges");
    ev_pin = 0; cyc(10);
    check("R4", cnt_lo, 8'h16, "low level counts once");
    ev_pin = 1; @(negedge clk);

    phase = "R5";
    gate_en = 1; gate_pin = 0;
    pulse_ev(3);
    check("R5", cnt_lo, 8'h16, "gate low blocks");
    gate_pin = 1;
    pulse_ev(2);
    check("R5", cnt_lo, 8'h18, "gate high counts");
    run0 = 0;
    pulse_ev(2);
    check("R5", cnt_lo, 8'h18, "run0 low blocks");
    run0 = 1; gate_en = 0;

    phase = "R9";
    ev_pin = 0; wr_en = 1; wr_sel = 0; wr_data = 8'h55;
    @(negedge clk); wr_en = 0; ev_pin = 1;
    check("R9", cnt_lo, 8'h55, "write beats edge");
    wr(2'd1, 8'hA5);
    check("R9", cnt_hi, 8'hA5, "write high byte");

    phase = "R6";
    split_mode = 1; div_fast = 1;
    wr(2'd0, 8'hFF); wr(2'd1, 8'hFD);
    pulse_ev(1);
    check("R6", cnt_lo, 8'h00, "split low wraps to zero");
    check("R6", ovf0, 1, "split ovf0");
    run1 = 1;
    cyc(40);
    check("R6", ovf1, 1, "split ovf1 after high wrap");

    phase = "R8";
    wr(2'd2, 8'h02);
    check("R8", ovf1, 0, "write clears ovf1");
    check("R8", ovf0, 1, "ovf0 kept by write of bit1 only");
    wr(2'd2, 8'h01);
    check("R8", ovf0, 0, "write clears ovf0");

    phase = "R7";
    split_mode = 0; run1 = 1;
    wr(2'd1, 8'hFF);
    cyc(60); run1 = 0; cyc(5); run1 = 1; cyc(30);
    check("R7", cnt_hi, 8'hFF, "high byte idle in reload mode");
    check("R7", ovf1, 0, "ovf1 quiet in reload mode");

    phase = "R3";
    ext_sel = 0; div_fast = 0;
    cyc(400);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule